// File: doc/BRIEF.md
# Serial Flash Start-up Probe

This controller runs once after reset. It works out which serial NOR flash is attached, and on an accepted part it readies that part for programming. It drives a byte-wide SPI shifter through a request/done handshake and controls the chip-select line itself.

It first sends the identification opcode and collects three reply bytes: vendor, memory family and density. The vendor and family bytes are checked against a fixed list. The density code becomes a count of 4 KB erase sectors. On an accepted part, and with writes allowed, the controller then sends two transactions. The first sets the part's write latch. The second writes a status value that clears every block-protect bit (status bits 2 to 5) and the status-protect bit (bit 7).

The block has two end states. In the first, `ready` is high and the sector count is valid. In the second, `unsupported` is high and the count stays at zero. Each end state holds until the next reset. Surrounding logic waits for one of the two flags before it issues page, read or erase traffic of its own.

Top module: `flash_probe`

## Requirements
- R1: While reset is high and on the first cycle after it, `flash_cs_n` is 1, `xfer_req` is 0, `ready` and `unsupported` are 0 and `sector_count` is 0. After reset is released, chip select stays high for at least LEAD_CYCLES (default 2) clock cycles before the first transaction.
- R2: The first chip-select window carries exactly four bytes. The first is opcode 0x9F and the next three are filler 0xFF. The bytes received on bytes 2, 3 and 4 are taken in that order as vendor, family and density.
- R3: The part is accepted only when the vendor byte is 0xEF and the family byte is one of 0x30, 0x40, 0x50 or 0x60.
- R4: The density code must also lie in 0x14..0x18, and it maps to 256 << (code - 0x14) sectors: 256, 512, 1024, 2048 or 4096. Any other density code rejects the part.
- R5: With `read_only` low, an accepted part gets exactly two more windows. The second window carries only 0x06. The third carries 0x01, 0x00, 0x00. Chip select goes high between the windows.
- R6: A rejected part sets `unsupported`, which stays high until reset. In that case `ready` stays 0, `sector_count` stays 0 and no transaction follows the identification window.
- R7: With `read_only` high, an accepted part gets no transaction after the identification window, and `ready` still rises.
- R8: `ready` or `unsupported` rises exactly one clock after `flash_cs_n` rises at the end of the last window. `sector_count` is zero until `ready` is high.
- R9: `xfer_req` is a one-cycle pulse that occurs only while chip select is low, and never while a byte is still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| read_only | input | 1 | When high, the protection-clearing writes are skipped |
| xfer_req | output | 1 | One-cycle request to the shifter to exchange one byte |
| xfer_tx | output | 8 | Byte to send, valid with `xfer_req` |
| xfer_done | input | 1 | One-cycle pulse from the shifter when the exchange has finished |
| xfer_rx | input | 8 | Byte received, valid with `xfer_done` |
| flash_cs_n | output | 1 | Flash chip select, active low |
| ready | output | 1 | Part accepted and prepared; sticky until reset |
| unsupported | output | 1 | Part rejected; sticky until reset |
| sector_count | output | SECT_W | Number of 4 KB sectors, valid while `ready` is high |

## Verification
Every accepted density code is run, paired across the four accepted family codes, so each table row and each family match shows up in both the flag and the sector count. Rejection is tried with three inputs: a wrong vendor byte, an unknown family byte, and density codes just below and just above the accepted range. These separate the three checks and the range edges. The read-only input is set on both an accepted and a rejected part, which shows that the write sequence depends on the decision and the mode together. The shifter reply latency is varied so that the handshake cannot hold up only on fixed timing.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

  typedef enum logic [2:0] {
    ST_LEAD,
    ST_XFER,
    ST_TAIL,
    ST_READY,
    ST_REJECT
  } probe_state_t;

  typedef enum logic [1:0] {
    PH_ID,
    PH_WREN,
    PH_WRSR
  } probe_phase_t;

  localparam logic [7:0] OP_READ_ID   = 8'h9F;
  localparam logic [7:0] OP_WRITE_EN  = 8'h06;
  localparam logic [7:0] OP_WRITE_SR  = 8'h01;
  localparam logic [7:0] FILL_BYTE    = 8'hFF;
  localparam logic [7:0] SR_CLEAR     = 8'h00;

  localparam logic [7:0] VENDOR_CODE  = 8'hEF;
  localparam int         NUM_FAMILIES = 4;
  localparam logic [7:0] FAMILY_CODES [NUM_FAMILIES] = '{8'h30, 8'h40, 8'h50, 8'h60};

  localparam logic [7:0] DENSITY_FIRST  = 8'h14;
  localparam int         DENSITY_STEPS  = 5;
  localparam int         BASE_SECT_LOG2 = 8;

  function automatic logic [1:0] phase_last(input probe_phase_t ph);
    case (ph)
      PH_ID:   return 2'd3;
      PH_WREN: return 2'd0;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [7:0] phase_byte(input probe_phase_t ph, input logic [1:0] idx);
    case (ph)
      PH_ID:   return (idx == 2'd0) ? OP_READ_ID : FILL_BYTE;
      PH_WREN: return OP_WRITE_EN;
      default: return (idx == 2'd0) ? OP_WRITE_SR : SR_CLEAR;
    endcase
  endfunction

endpackage

// File: rtl/flash_id_decode.sv
module flash_id_decode
  import flash_probe_pkg::*;
#(
  parameter int SECT_W = 13
) (
  input  logic [7:0]        vendor,
  input  logic [7:0]        family,
  input  logic [7:0]        density,
  output logic              accept,
  output logic [SECT_W-1:0] sectors
);

  localparam int MAX_LOG2 = BASE_SECT_LOG2 + DENSITY_STEPS - 1;

  logic [NUM_FAMILIES-1:0]  family_hit;
  logic [DENSITY_STEPS-1:0] density_hit;

  for (genvar g = 0; g < NUM_FAMILIES; g++) begin : g_family
    assign family_hit[g] = (family == FAMILY_CODES[g]);
  end

  for (genvar k = 0; k < DENSITY_STEPS; k++) begin : g_density
    assign density_hit[k] = (density == DENSITY_FIRST + 8'(k));
  end

  always_comb begin
    sectors = '0;
    for (int k = 0; k < DENSITY_STEPS; k++) begin
      if (density_hit[k] && (BASE_SECT_LOG2 + k) < SECT_W)
        sectors = sectors | (SECT_W'(1) << (BASE_SECT_LOG2 + k));
    end
    accept = (vendor == VENDOR_CODE) && (|family_hit) && (|density_hit)
             && (MAX_LOG2 < SECT_W);
    if (!accept)
      sectors = '0;
  end

endmodule

// File: rtl/flash_probe_seq.sv
module flash_probe_seq
  import flash_probe_pkg::*;
#(
  parameter int LEAD_CYCLES = 2,
  parameter int SECT_W      = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              read_only,
  input  logic              xfer_done,
  input  logic [7:0]        xfer_rx,
  input  logic              id_accept,
  input  logic [SECT_W-1:0] id_sectors,
  output logic              xfer_req,
  output logic [7:0]        xfer_tx,
  output logic              flash_cs_n,
  output logic [7:0]        id_vendor,
  output logic [7:0]        id_family,
  output logic [7:0]        id_density,
  output logic              ready,
  output logic              unsupported,
  output logic [SECT_W-1:0] sector_count
);

  localparam int GAP_W = $clog2(LEAD_CYCLES + 1);
  localparam logic [GAP_W-1:0] GAP_END = GAP_W'(LEAD_CYCLES - 1);

  probe_state_t state;
  probe_phase_t phase;
  logic [1:0]       idx;
  logic             busy;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_LEAD;
      phase        <= PH_ID;
      idx          <= '0;
      busy         <= 1'b0;
      gap          <= '0;
      flash_cs_n   <= 1'b1;
      xfer_req     <= 1'b0;
      xfer_tx      <= '0;
      id_vendor    <= '0;
      id_family    <= '0;
      id_density   <= '0;
      ready        <= 1'b0;
      unsupported  <= 1'b0;
      sector_count <= '0;
    end else begin
      xfer_req <= 1'b0;
      case (state)
        ST_LEAD: begin
          if (gap == GAP_END) begin
            gap        <= '0;
            idx        <= '0;
            busy       <= 1'b0;
            flash_cs_n <= 1'b0;
            state      <= ST_XFER;
          end else begin
            gap <= gap + 1'b1;
          end
        end
        ST_XFER: begin
          if (!busy) begin
            xfer_req <= 1'b1;
            xfer_tx  <= phase_byte(phase, idx);
            busy     <= 1'b1;
          end else if (xfer_done) begin
            busy <= 1'b0;
            if (phase == PH_ID) begin
              case (idx)
                2'd1:    id_vendor  <= xfer_rx;
                2'd2:    id_family  <= xfer_rx;
                2'd3:    id_density <= xfer_rx;
                default: ;
              endcase
            end
            if (idx == phase_last(phase)) begin
              flash_cs_n <= 1'b1;
              state      <= ST_TAIL;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_TAIL: begin
          case (phase)
            PH_ID: begin
              if (!id_accept) begin
                unsupported <= 1'b1;
                state       <= ST_REJECT;
              end else if (read_only) begin
                ready        <= 1'b1;
                sector_count <= id_sectors;
                state        <= ST_READY;
              end else begin
                phase <= PH_WREN;
                state <= ST_LEAD;
              end
            end
            PH_WREN: begin
              phase <= PH_WRSR;
              state <= ST_LEAD;
            end
            default: begin
              ready        <= 1'b1;
              sector_count <= id_sectors;
              state        <= ST_READY;
            end
          endcase
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/flash_probe.sv
module flash_probe
  import flash_probe_pkg::*;
#(
  parameter int LEAD_CYCLES = 2,
  parameter int SECT_W      = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              read_only,
  output logic              xfer_req,
  output logic [7:0]        xfer_tx,
  input  logic              xfer_done,
  input  logic [7:0]        xfer_rx,
  output logic              flash_cs_n,
  output logic              ready,
  output logic              unsupported,
  output logic [SECT_W-1:0] sector_count
);

  logic [7:0]        id_vendor;
  logic [7:0]        id_family;
  logic [7:0]        id_density;
  logic              id_accept;
  logic [SECT_W-1:0] id_sectors;

  flash_id_decode #(.SECT_W(SECT_W)) u_decode (
    .vendor  (id_vendor),
    .family  (id_family),
    .density (id_density),
    .accept  (id_accept),
    .sectors (id_sectors)
  );

  flash_probe_seq #(.LEAD_CYCLES(LEAD_CYCLES), .SECT_W(SECT_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .read_only    (read_only),
    .xfer_done    (xfer_done),
    .xfer_rx      (xfer_rx),
    .id_accept    (id_accept),
    .id_sectors   (id_sectors),
    .xfer_req     (xfer_req),
    .xfer_tx      (xfer_tx),
    .flash_cs_n   (flash_cs_n),
    .id_vendor    (id_vendor),
    .id_family    (id_family),
    .id_density   (id_density),
    .ready        (ready),
    .unsupported  (unsupported),
    .sector_count (sector_count)
  );

endmodule

// File: rtl/flash_probe_chk.sv
module flash_probe_chk #(
  parameter int SECT_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_req,
  input logic              xfer_done,
  input logic              flash_cs_n,
  input logic              ready,
  input logic              unsupported,
  input logic [SECT_W-1:0] sector_count
);

  AST_REQ_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> !flash_cs_n) else $error("request while deselected"); // R9

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    xfer_req |=> !xfer_req) else $error("request longer than one cycle"); // R9

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ready && unsupported)) else $error("both end flags high"); // R6

  AST_UNSUP_STICKY: assert property (@(posedge clk) disable iff (rst)
    unsupported |=> unsupported) else $error("unsupported dropped"); // R6

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready) else $error("ready dropped"); // R8

  AST_QUIET_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    (ready || unsupported) |-> (flash_cs_n && !xfer_req)) else $error("traffic after end"); // R6

  AST_COUNT_ZERO_EARLY: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (sector_count == '0)) else $error("count before ready"); // R8

  AST_COUNT_POWER_TWO: assert property (@(posedge clk) disable iff (rst)
    ready |-> ($countones(sector_count) == 1)) else $error("count not a table value"); // R4

  AST_READY_AFTER_DESELECT: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(flash_cs_n) && !$past(flash_cs_n, 2))) else $error("ready timing"); // R8

  AST_UNSUP_AFTER_DESELECT: assert property (@(posedge clk) disable iff (rst)
    $rose(unsupported) |-> ($past(flash_cs_n) && !$past(flash_cs_n, 2))) else $error("reject timing"); // R8

  AST_DONE_NOT_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> !xfer_done) else $error("request while byte outstanding"); // R9

endmodule

bind flash_probe flash_probe_chk #(.SECT_W(SECT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .xfer_req     (xfer_req),
  .xfer_done    (xfer_done),
  .flash_cs_n   (flash_cs_n),
  .ready        (ready),
  .unsupported  (unsupported),
  .sector_count (sector_count)
);

// File: tb/test_flash_probe.sv
module test_flash_probe;

  localparam int LEAD   = 2;
  localparam int SECT_W = 13;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              read_only = 1'b0;
  logic              xfer_req;
  logic [7:0]        xfer_tx;
  logic              xfer_done = 1'b0;
  logic [7:0]        xfer_rx = 8'h00;
  logic              flash_cs_n;
  logic              ready;
  logic              unsupported;
  logic [SECT_W-1:0] sector_count;

  always #5 clk = ~clk;

  flash_probe #(.LEAD_CYCLES(LEAD), .SECT_W(SECT_W)) i_flash_probe (
    .clk (clk), .rst (rst), .read_only (read_only),
    .xfer_req (xfer_req), .xfer_tx (xfer_tx),
    .xfer_done (xfer_done), .xfer_rx (xfer_rx),
    .flash_cs_n (flash_cs_n), .ready (ready),
    .unsupported (unsupported), .sector_count (sector_count)
  );

  int n_chk = 0;
  int n_fail = 0;

  // shifter model and monitor state
  logic [7:0] id_v, id_f, id_d, pend;
  int lat = 1;
  int cd = 0, pos = 0, cyc = 0;
  int n_tx = 0, n_txn = 0, req_bad = 0, lead_hi = 0;
  int cs_rise = 0, rdy_cyc = 0, uns_cyc = 0;
  bit seen_low = 0;
  logic prev_cs = 1'b1, prev_rdy = 1'b0, prev_uns = 1'b0;
  logic [7:0] log_val [64];
  int         log_txn [64];

  always @(negedge clk) begin
    cyc++;
    xfer_done = 1'b0;
    if (cd != 0) begin
      cd--;
      if (cd == 0) begin
        xfer_done = 1'b1;
        xfer_rx   = pend;
      end
    end
    if (rst) begin
      pos = 0;
      cd  = 0;
    end else begin
      if (flash_cs_n) pos = 0;
      if (prev_cs && !flash_cs_n) n_txn++;
      if (!prev_cs && flash_cs_n) cs_rise = cyc;
      if (ready && !prev_rdy) rdy_cyc = cyc;
      if (unsupported && !prev_uns) uns_cyc = cyc;
      if (!seen_low) begin
        if (flash_cs_n) lead_hi++;
        else seen_low = 1;
      end
      if (xfer_req) begin
        if (flash_cs_n || cd != 0 || xfer_done) req_bad++;
        if (n_tx < 64) begin
          log_val[n_tx] = xfer_tx;
          log_txn[n_tx] = n_txn;
        end
        n_tx++;
        case (pos)
          1:       pend = id_v;
          2:       pend = id_f;
          3:       pend = id_d;
          default: pend = 8'h00;
        endcase
        pos++;
        cd = lat;
      end
    end
    prev_cs  = flash_cs_n;
    prev_rdy = ready;
    prev_uns = unsupported;
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic run_case(input string tag, input logic ro, input logic [7:0] v,
                          input logic [7:0] f, input logic [7:0] d,
                          input bit exp_ok, input int exp_sect, input int lat_i);
    int  waited;
    bit  timed_out;
    int  exp_txn;
    int  exp_bytes;
    @(posedge clk); #1;
    rst = 1'b1; read_only = ro; id_v = v; id_f = f; id_d = d; lat = lat_i;
    repeat (3) @(posedge clk);
    #1;
    n_tx = 0; n_txn = 0; req_bad = 0; lead_hi = 0; seen_low = 0;
    cs_rise = 0; rdy_cyc = 0; uns_cyc = 0;
    @(negedge clk);
    // R1: values held in reset
    chk(flash_cs_n === 1'b1 && xfer_req === 1'b0 && ready === 1'b0 &&
        unsupported === 1'b0 && sector_count === '0, "R1", {tag, " reset state"},
        {flash_cs_n, xfer_req, ready, unsupported}, 4'b1000);
    @(posedge clk); #1;
    rst = 1'b0;
    waited = 0;
    timed_out = 0;
    while (!(ready || unsupported)) begin
      @(negedge clk);
      waited++;
      if (waited > 5000) begin
        timed_out = 1;
        break;
      end
    end
    chk(!timed_out, "R8", {tag, " end flag within timeout"}, waited, 5000);
    repeat (20) @(negedge clk);

    chk(lead_hi >= LEAD, "R1", {tag, " select held high before first window"}, lead_hi, LEAD);
    chk(req_bad == 0, "R9", {tag, " request protocol"}, req_bad, 0);

    // R3 R4 R6 R7: decision
    chk(ready == exp_ok && unsupported == !exp_ok, exp_ok ? "R3" : "R6",
        {tag, " end flags"}, {ready, unsupported}, {exp_ok, !exp_ok});
    chk(sector_count == SECT_W'(exp_sect), "R4", {tag, " sector count"}, sector_count, exp_sect);

    // R2: identification window
    chk(n_tx >= 4 && log_val[0] == 8'h9F && log_val[1] == 8'hFF && log_val[2] == 8'hFF &&
        log_val[3] == 8'hFF && log_txn[0] == 1 && log_txn[3] == 1,
        "R2", {tag, " identification bytes"}, log_val[0], 8'h9F);

    exp_txn   = (exp_ok && !ro) ? 3 : 1;
    exp_bytes = (exp_ok && !ro) ? 8 : 4;
    chk(n_txn == exp_txn && n_tx == exp_bytes, (exp_ok && !ro) ? "R5" : (exp_ok ? "R7" : "R6"),
        {tag, " window count"}, n_txn, exp_txn);
    if (exp_ok && !ro && n_tx == 8) begin
      // R5: write latch window then status window with zeros
      chk(log_val[4] == 8'h06 && log_txn[4] == 2, "R5", {tag, " write-enable window"}, log_val[4], 8'h06);
      chk(log_val[5] == 8'h01 && log_val[6] == 8'h00 && log_val[7] == 8'h00 &&
          log_txn[5] == 3 && log_txn[7] == 3, "R5", {tag, " status write window"},
          {log_val[5], log_val[6], log_val[7]}, 24'h010000);
    end
    // R8: flag rises one clock after deselect
    chk((exp_ok ? rdy_cyc : uns_cyc) - cs_rise == 1, "R8", {tag, " flag delay"},
        (exp_ok ? rdy_cyc : uns_cyc) - cs_rise, 1);
  endtask

  initial begin
    run_case("accept_40_17", 1'b0, 8'hEF, 8'h40, 8'h17, 1'b1, 2048, 1);
    run_case("cap_14", 1'b0, 8'hEF, 8'h30, 8'h14, 1'b1, 256, 2);
    run_case("cap_15", 1'b0, 8'hEF, 8'h50, 8'h15, 1'b1, 512, 3);
    run_case("cap_16", 1'b0, 8'hEF, 8'h60, 8'h16, 1'b1, 1024, 1);
    run_case("cap_18", 1'b0, 8'hEF, 8'h40, 8'h18, 1'b1, 4096, 4);
    run_case("bad_vendor", 1'b0, 8'hC2, 8'h40, 8'h17, 1'b0, 0, 1);
    run_case("bad_family", 1'b0, 8'hEF, 8'h20, 8'h16, 1'b0, 0, 2);
    run_case("cap_low", 1'b0, 8'hEF, 8'h30, 8'h13, 1'b0, 0, 1);
    run_case("cap_high", 1'b0, 8'hEF, 8'h60, 8'h19, 1'b0, 0, 3);
    run_case("ro_accept", 1'b1, 8'hEF, 8'h30, 8'h16, 1'b1, 1024, 2);
    run_case("ro_reject", 1'b1, 8'hEF, 8'h70, 8'h16, 1'b0, 0, 1);
    // R6: flag stays set well after rejection
    repeat (200) @(negedge clk);
    chk(unsupported == 1'b1 && ready == 1'b0 && flash_cs_n == 1'b1, "R6",
        "reject flag still held", unsupported, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule